// File: doc/BRIEF.md
# Pulse Timestamp Pipeline

This block holds timestamps for four beam pulses: the pulse being served now and the three that come after it. Each slot stores a seconds word, a nanoseconds word and a validity status. On every fiducial strobe the slots shift one place toward "now". The slot that is three pulses ahead is loaded from the input port in that same update.

The low 17 bits of the nanoseconds word carry a pulse identifier. The block reads this identifier from every stamp it accepts and checks it. It counts identifiers that carry the invalid code, and it counts identifiers that do not follow on from the stamp loaded before them. Each of these events also sets a sticky error flag. When the three upcoming slots all hold the same stamp, the slot that moves into "now" is marked invalid.

A reader picks a slot with a two-bit index and gets that slot's stamp and status back one clock later. A synchronous clear strobe zeroes both counters and the flag.

Top module: `pulse_ts_pipe`

## Requirements
- R1: While `rst` is high, all four slots take `sys_sec`/`sys_nsec` with invalid status, and the counters and error flag go to zero.
- R2: The `rd_*` outputs show slot `rd_idx` as it stood before the clock edge that captured `rd_idx`. Slot 0 is the current pulse and slot k is k pulses ahead. The status reads 0x00000000 when valid and 0xFFFFFFFF when invalid.
- R3: When `fid` is high, slot k takes the contents of slot k+1 for k = 0 to 2. Slot 3 takes `new_sec`/`new_nsec`, with valid status exactly when `new_ok` is 1.
- R4: If slots 1, 2 and 3 hold identical stamps (both words) when `fid` is high, slot 0 is marked invalid after the shift, whatever the status of slot 1.
- R5: When `fid` is high and `new_nsec[16:0]` equals 0x1FFFF, `cnt_bad_id` increments and `err_flag` is set.
- R6: When `fid` is high, the new identifier is not 0x1FFFF, slot 3 is valid, slot 3's identifier is not 0x1FFFF, and the new identifier is not the successor of slot 3's identifier, then `cnt_seq` increments and `err_flag` is set.
- R7: Identifiers count modulo 0x1FFFF, so the successor of 0x1FFFE is 0x00000.
- R8: Both counters are 16 bits wide and stop at 0xFFFF.
- R9: `clr` zeroes both counters and `err_flag`. If an error is detected in the same cycle, the clear applies first: the affected counter reads 1 and the flag reads 1.
- R10: `err_flag` stays set until `clr` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sec | input | 32 | System-time seconds used at reset |
| sys_nsec | input | 32 | System-time nanoseconds used at reset |
| fid | input | 1 | Fiducial strobe: advance and load |
| new_sec | input | 32 | Seconds word of the three-ahead stamp |
| new_nsec | input | 32 | Nanoseconds word; bits 16:0 hold the pulse identifier |
| new_ok | input | 1 | Status of the incoming stamp (1 = valid) |
| clr | input | 1 | Clears the counters and the error flag |
| rd_idx | input | 2 | Slot to read |
| rd_sec | output | 32 | Seconds word of the selected slot |
| rd_nsec | output | 32 | Nanoseconds word of the selected slot |
| rd_stat | output | 32 | Status word of the selected slot |
| err_flag | output | 1 | Sticky error flag |
| cnt_bad_id | output | 16 | Count of invalid identifiers |
| cnt_seq | output | 16 | Count of non-consecutive identifiers |

## Verification
The clear strobe and error detection on a fiducial can land in the same cycle. The bench drives `clr` together with `fid` while feeding stamps whose identifier is invalid or out of sequence. It expects a count of exactly one and a set flag, not zero. A read can also share its capture edge with a shift. Every step therefore checks `rd_*` against the slot contents from before that edge. The sequences mix random jumps, invalid codes and repeated stamps with directed wrap, repeat and saturation cases.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 17;
  localparam logic [ID_W-1:0] ID_BAD = {ID_W{1'b1}};

  typedef struct packed {
    logic [WORD_W-1:0] sec;
    logic [WORD_W-1:0] nsec;
  } stamp_t;

  function automatic logic [ID_W-1:0] id_of(input stamp_t s);
    return s.nsec[ID_W-1:0];
  endfunction

  function automatic logic [ID_W-1:0] id_succ(input logic [ID_W-1:0] id);
    return (id == ID_BAD - 1'b1) ? '0 : id + 1'b1;
  endfunction
endpackage

// File: rtl/pts_store.sv
module pts_store
  import pts_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  stamp_t                init_stamp,
  input  logic                  adv,
  input  stamp_t                new_stamp,
  input  logic                  new_ok,
  output stamp_t [DEPTH-1:0]    slot_q,
  output logic   [DEPTH-1:0]    ok_q
);
  localparam int unsigned LAST = DEPTH - 1;

  // upcoming slots 1..LAST identical
  logic [LAST-1:0] same_v;
  logic            upcoming_same;

  assign same_v[0] = 1'b1;
  for (genvar k = 1; k < LAST; k++) begin : g_cmp
    assign same_v[k] = same_v[k-1] & (slot_q[k] == slot_q[k+1]);
  end
  assign upcoming_same = same_v[LAST-1];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[k] <= init_stamp;
        ok_q[k]   <= 1'b0;
      end else if (adv) begin
        if (k == LAST) begin
          slot_q[k] <= new_stamp;
          ok_q[k]   <= new_ok;
        end else begin
          slot_q[k] <= slot_q[k+1];
          ok_q[k]   <= (k == 0) ? (ok_q[k+1] & ~upcoming_same) : ok_q[k+1];
        end
      end
    end
  end
endmodule

// File: rtl/pts_idchk.sv
module pts_idchk
  import pts_pkg::*;
(
  input  logic            adv,
  input  logic [ID_W-1:0] new_id,
  input  logic [ID_W-1:0] prev_id,
  input  logic            prev_ok,
  output logic            bad_hit,
  output logic            seq_hit
);
  logic new_bad;
  logic prev_usable;

  always_comb begin
    new_bad     = (new_id == ID_BAD);
    prev_usable = prev_ok && (prev_id != ID_BAD);
    bad_hit     = adv && new_bad;
    seq_hit     = adv && !new_bad && prev_usable && (new_id != id_succ(prev_id));
  end
endmodule

// File: rtl/pts_sat_cnt.sv
module pts_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] base;

  always_comb base = clr ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && base != TOP) cnt <= base + 1'b1;
    else                        cnt <= base;
  end
endmodule

// File: rtl/pulse_ts_pipe.sv
module pulse_ts_pipe
  import pts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       sys_sec,
  input  logic [31:0]       sys_nsec,
  input  logic              fid,
  input  logic [31:0]       new_sec,
  input  logic [31:0]       new_nsec,
  input  logic              new_ok,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_sec,
  output logic [31:0]       rd_nsec,
  output logic [31:0]       rd_stat,
  output logic              err_flag,
  output logic [CNT_W-1:0]  cnt_bad_id,
  output logic [CNT_W-1:0]  cnt_seq
);
  stamp_t               init_s, new_s;
  stamp_t [DEPTH-1:0]   slots;
  logic   [DEPTH-1:0]   oks;
  logic                 bad_hit, seq_hit;

  assign init_s = '{sec: sys_sec, nsec: sys_nsec};
  assign new_s  = '{sec: new_sec, nsec: new_nsec};

  pts_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .init_stamp(init_s), .adv(fid),
    .new_stamp(new_s), .new_ok(new_ok), .slot_q(slots), .ok_q(oks)
  );

  pts_idchk u_idchk (
    .adv(fid), .new_id(new_nsec[ID_W-1:0]),
    .prev_id(id_of(slots[DEPTH-1])), .prev_ok(oks[DEPTH-1]),
    .bad_hit(bad_hit), .seq_hit(seq_hit)
  );

  pts_sat_cnt #(.W(CNT_W)) u_cnt_bad (
    .clk(clk), .rst(rst), .clr(clr), .inc(bad_hit), .cnt(cnt_bad_id)
  );

  pts_sat_cnt #(.W(CNT_W)) u_cnt_seq (
    .clk(clk), .rst(rst), .clr(clr), .inc(seq_hit), .cnt(cnt_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) err_flag <= 1'b0;
    else     err_flag <= (err_flag & ~clr) | bad_hit | seq_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sec  <= '0;
      rd_nsec <= '0;
      rd_stat <= '1;
    end else begin
      rd_sec  <= slots[rd_idx].sec;
      rd_nsec <= slots[rd_idx].nsec;
      rd_stat <= oks[rd_idx] ? '0 : '1;
    end
  end
endmodule

// File: rtl/pulse_ts_pipe_chk.sv
module pulse_ts_pipe_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fid,
  input logic             clr,
  input logic [31:0]      new_nsec,
  input logic [31:0]      rd_stat,
  input logic             err_flag,
  input logic [CNT_W-1:0] cnt_bad_id,
  input logic [CNT_W-1:0] cnt_seq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic seen_rst = 1'b0;
  logic past_ok  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    past_ok <= seen_rst & ~rst;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (cnt_bad_id == '0 && cnt_seq == '0 && !err_flag));

  // R2
  stat_code_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (rd_stat == 32'h0 || rd_stat == 32'hFFFF_FFFF));

  // R5
  bad_id_count_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (fid && new_nsec[16:0] == 17'h1FFFF && !clr && cnt_bad_id != TOP)
      |=> cnt_bad_id == $past(cnt_bad_id) + 1'b1);

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cnt_bad_id == TOP && !clr) |=> cnt_bad_id == TOP);

  // R8
  no_decrease_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !clr |=> (cnt_seq >= $past(cnt_seq) && cnt_bad_id >= $past(cnt_bad_id)));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr && !fid) |=> (cnt_bad_id == '0 && cnt_seq == '0 && !err_flag));

  // R9
  clear_with_bad_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (clr && fid && new_nsec[16:0] == 17'h1FFFF) |=> (cnt_bad_id == 1 && err_flag));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (err_flag && !clr) |=> err_flag);
endmodule

bind pulse_ts_pipe pulse_ts_pipe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fid(fid), .clr(clr), .new_nsec(new_nsec),
  .rd_stat(rd_stat), .err_flag(err_flag), .cnt_bad_id(cnt_bad_id), .cnt_seq(cnt_seq)
);

// File: tb/pulse_ts_pipe_bench.sv
module pulse_ts_pipe_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] sys_sec, sys_nsec, new_sec, new_nsec;
  logic        fid, new_ok, clr;
  logic [1:0]  rd_idx;
  logic [31:0] rd_sec, rd_nsec, rd_stat;
  logic        err_flag;
  logic [15:0] cnt_bad_id, cnt_seq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sec [4];
  logic [31:0] m_nsec[4];
  bit          m_ok  [4];
  int          m_bad, m_seq;
  bit          m_flag;

  always #10 clk = ~clk;

  pulse_ts_pipe u_pulse_ts_pipe (
    .clk(clk), .rst(rst), .sys_sec(sys_sec), .sys_nsec(sys_nsec), .fid(fid),
    .new_sec(new_sec), .new_nsec(new_nsec), .new_ok(new_ok), .clr(clr),
    .rd_idx(rd_idx), .rd_sec(rd_sec), .rd_nsec(rd_nsec), .rd_stat(rd_stat),
    .err_flag(err_flag), .cnt_bad_id(cnt_bad_id), .cnt_seq(cnt_seq)
  );

  function automatic logic [16:0] nxt(input logic [16:0] id);
    return (id == 17'h1FFFE) ? 17'h0 : id + 17'h1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step(input bit a, input bit c, input logic [31:0] s,
                            input logic [31:0] n, input bit ok);
    bit rpt, bad, sq;
    int base;
    rpt = 0; bad = 0; sq = 0;
    if (a) begin
      rpt = (m_sec[1] == m_sec[2]) && (m_nsec[1] == m_nsec[2]) &&
            (m_sec[2] == m_sec[3]) && (m_nsec[2] == m_nsec[3]);
      bad = (n[16:0] == 17'h1FFFF);
      sq  = !bad && m_ok[3] && (m_nsec[3][16:0] != 17'h1FFFF) && (n[16:0] != nxt(m_nsec[3][16:0]));
      for (int k = 0; k < 3; k++) begin
        m_sec[k] = m_sec[k+1]; m_nsec[k] = m_nsec[k+1]; m_ok[k] = m_ok[k+1];
      end
      if (rpt) m_ok[0] = 0;
      m_sec[3] = s; m_nsec[3] = n; m_ok[3] = ok;
    end
    base = c ? 0 : m_bad;
    m_bad = (bad && base < 65535) ? base + 1 : base;
    base = c ? 0 : m_seq;
    m_seq = (sq && base < 65535) ? base + 1 : base;
    m_flag = (c ? 1'b0 : m_flag) | bad | sq;
  endtask

  // one clock step: inputs driven at negedge, outputs sampled at next negedge
  task automatic tick(input bit a, input bit c, input logic [31:0] s, input logic [31:0] n,
                      input bit ok, input logic [1:0] idx, input string req);
    logic [31:0] es, en, est;
    fid = a; clr = c; new_sec = s; new_nsec = n; new_ok = ok; rd_idx = idx;
    @(posedge clk);
    es = m_sec[idx]; en = m_nsec[idx]; est = m_ok[idx] ? 32'h0 : 32'hFFFF_FFFF;
    model_step(a, c, s, n, ok);
    @(negedge clk);
    fid = 0; clr = 0;
    chk({req, " R2 rd_sec"},  rd_sec,  es);
    chk({req, " R2 rd_nsec"}, rd_nsec, en);
    chk({req, " R2 rd_stat"}, rd_stat, est);
    chk({req, " cnt_bad_id"}, {16'h0, cnt_bad_id}, m_bad[31:0]);
    chk({req, " cnt_seq"},    {16'h0, cnt_seq},    m_seq[31:0]);
    chk({req, " err_flag"},   {31'h0, err_flag},   {31'h0, m_flag});
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) tick(0, 0, 0, 0, 0, k[1:0], req);
  endtask

  function automatic logic [31:0] mk_n(input logic [16:0] id, input logic [14:0] hi);
    return {hi, id};
  endfunction

  initial begin
    logic [16:0] cur;
    logic [31:0] sec;
    int r;
    void'($urandom(32'd1234));
    rst = 1; fid = 0; clr = 0; new_ok = 0; rd_idx = 0;
    new_sec = 0; new_nsec = 0;
    sys_sec = 32'h2A00_1111; sys_nsec = 32'h0BAD_1FFF;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int k = 0; k < 4; k++) begin
      m_sec[k] = sys_sec; m_nsec[k] = sys_nsec; m_ok[k] = 0;
    end
    m_bad = 0; m_seq = 0; m_flag = 0;
    // R1: reset state of every slot and of the counters
    read_all("R1 reset");

    // R3 R7: wrap from 0x1FFFE to 0 is consecutive
    sec = 32'd500;
    tick(1, 0, sec,   mk_n(17'h1FFFC, 15'd7), 1, 0, "R3 load");
    tick(1, 0, sec+1, mk_n(17'h1FFFD, 15'd7), 1, 3, "R3 load");
    tick(1, 0, sec+2, mk_n(17'h1FFFE, 15'd7), 1, 2, "R7 wrap");
    tick(1, 0, sec+3, mk_n(17'h00000, 15'd7), 1, 1, "R7 wrap");
    chk("R7 no seq error across wrap", {16'h0, cnt_seq}, 32'd0);
    read_all("R3 shifted");

    // R6: jump
    tick(1, 0, sec+4, mk_n(17'h00005, 15'd7), 1, 0, "R6 jump");
    chk("R6 seq count", {16'h0, cnt_seq}, 32'd1);
    // R5 R10: invalid id
    tick(1, 0, sec+5, mk_n(17'h1FFFF, 15'd7), 1, 0, "R5 bad id");
    chk("R5 bad count", {16'h0, cnt_bad_id}, 32'd1);
    tick(0, 0, 0, 0, 0, 0, "R10 sticky");
    chk("R10 flag held", {31'h0, err_flag}, 32'd1);
    // R9: clear alone, then clear with bad id and with jump in same cycle
    tick(0, 1, 0, 0, 0, 0, "R9 clear");
    chk("R9 flag cleared", {31'h0, err_flag}, 32'd0);
    tick(1, 0, sec+6, mk_n(17'h00100, 15'd7), 1, 0, "R9 prep");
    tick(1, 1, sec+7, mk_n(17'h1FFFF, 15'd7), 1, 0, "R9 clr+bad");
    chk("R9 bad after clr+hit", {16'h0, cnt_bad_id}, 32'd1);
    tick(1, 0, sec+8, mk_n(17'h00200, 15'd7), 1, 0, "R9 prep");
    tick(1, 1, sec+9, mk_n(17'h00300, 15'd7), 1, 0, "R9 clr+seq");
    chk("R9 seq after clr+hit", {16'h0, cnt_seq}, 32'd1);

    // R4: three identical upcoming stamps invalidate the slot entering current
    tick(1, 0, 32'd900, mk_n(17'h00400, 15'd3), 1, 0, "R4 rep");
    tick(1, 0, 32'd900, mk_n(17'h00400, 15'd3), 1, 0, "R4 rep");
    tick(1, 0, 32'd900, mk_n(17'h00400, 15'd3), 1, 0, "R4 rep");
    tick(1, 0, 32'd901, mk_n(17'h00401, 15'd3), 1, 0, "R4 adv");
    tick(0, 0, 0, 0, 0, 0, "R4 read");
    chk("R4 slot0 invalid", rd_stat, 32'hFFFF_FFFF);

    // R8: saturation
    tick(0, 1, 0, 0, 0, 0, "R8 clear");
    for (int i = 0; i < 65540; i++)
      tick(1, 0, 32'd7, mk_n(17'h1FFFF, 15'd1), 1, i[1:0], "R8 sat");
    chk("R8 saturated", {16'h0, cnt_bad_id}, 32'h0000_FFFF);

    // random mix
    tick(0, 1, 0, 0, 0, 0, "rand clear");
    cur = 17'h1FF00; sec = 32'd10000;
    for (int i = 0; i < 3000; i++) begin
      r = $urandom_range(0, 99);
      if (r < 65)      begin cur = nxt(cur); sec = sec + 1; end
      else if (r < 75) begin cur = $urandom_range(0, 17'h1FFFE); sec = sec + 1; end
      else if (r < 85) cur = 17'h1FFFF;
      if (r >= 85) begin
        tick(1, ($urandom_range(0, 9) == 0), m_sec[3], m_nsec[3], 1,
             $urandom_range(0, 3), "R4 rand repeat");
      end else begin
        tick(1, ($urandom_range(0, 19) == 0), sec, mk_n(cur, 15'($urandom)),
             ($urandom_range(0, 9) != 0), $urandom_range(0, 3), "R3 R5 R6 rand");
        if (cur == 17'h1FFFF) cur = 17'h0;
      end
      if ($urandom_range(0, 3) == 0)
        tick(0, ($urandom_range(0, 29) == 0), 0, 0, 0, $urandom_range(0, 3), "R2 rand read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule